// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block is a small direct-mapped cache of address translations. Each set holds one shared data word: the physical-minus-virtual page offset. Each set also holds three independent tags, one for each kind of access: instruction fetch, data load and data store.

A lookup names a virtual page number and an access kind. One cycle later the block reports a hit and the stored offset, or a miss. A refill, issued after a page walk on a miss, writes the offset and the tag of one access kind. In the same set it drops the tags of the other kinds that belong to a different page. A flush empties every tag at once.

A per-kind trigger-watch input makes refilled tags carry a marker bit. A marked tag never hits, so accesses of that kind keep taking the slow path, where debug triggers are compared.

Each tag is in one of three states:
- **Invalid**: all ones.
- **Live**: marker clear, page number stored.
- **Marked**: marker set, page number stored.

The transitions are as follows:
- **Fill**: a refill of the tag's own kind moves it to live or marked.
- **Evict**: a refill of another kind for a different page moves it to invalid.
- **Flush** and **reset**: move it to invalid.

Top module: `tlb_split_top`

## Requirements
- R1: After reset every tag of every kind is invalid, so every lookup misses. `out_valid` is low while no lookup is pending.
- R2: A lookup presented at a clock edge with `lk_valid` high yields `out_valid` high at the next edge. Without a lookup, `out_valid`, `out_hit` and `out_ofs` are all zero.
- R3: A lookup hits when the requested kind's tag equals the page number with the marker bit clear. On a hit, `out_ofs` is the set's shared offset. On a miss, `out_ofs` is zero.
- R4: The set index is the page number modulo ENTRIES (its low bits). Two pages that share a set and differ in upper bits never hit for each other.
- R5: A refill writes the tag of its own kind only. The offset word is shared, so an existing tag of another kind for the same page keeps hitting and returns the new offset.
- R6: A refill invalidates, in its set, every tag of the other kinds whose page number (marker ignored) differs from the refilled page.
- R7: When the watch bit of the refilling kind is set (`watch[0]` fetch, `watch[1]` load, `watch[2]` store), the written tag carries the marker and lookups of it miss. A later refill of that kind without the watch bit makes it hit again.
- R8: Flush invalidates all tags. A refill in the same cycle as a flush leaves no tag behind.
- R9: A lookup in the same cycle as a refill or flush sees the contents from before that refill or flush.
- R10: Access kind codes are 0 fetch, 1 load, 2 store. Code 3 always misses on lookup, and on refill it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all tags |
| lk_valid | input | 1 | Lookup request |
| lk_kind | input | 2 | Lookup access kind (0 fetch, 1 load, 2 store) |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| rf_valid | input | 1 | Refill request |
| rf_kind | input | 2 | Refill access kind |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_ofs | input | OFS_W | Physical-minus-virtual offset to store |
| watch | input | 3 | Trigger watch per kind (bit 0 fetch, 1 load, 2 store) |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | 1 | Lookup hit |
| out_ofs | output | OFS_W | Offset on hit, zero otherwise |

## Verification
The hardest situation to reach from the ports is a set whose three tags disagree: one kind live, one marked, one evicted. In that state the shared offset must still serve the surviving kind. The bench reaches it with a sweep over a small configuration. Every page and kind is refilled in turn under a rotating watch pattern. After each refill, all pages of all kinds are looked up and compared against an arithmetic model of the three tag arrays. Directed steps add same-cycle refill with lookup, and flush with refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_NONE  = 2'd3
    } acc_kind_e;

    localparam int NUM_KINDS = 3;
endpackage

// File: rtl/tlb_tag_bank.sv
module tlb_tag_bank
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int KIND_ID = 0,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = VPN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             rf_en,
    input  logic [1:0]       rf_kind,
    input  logic [IDX_W-1:0] rf_idx,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic             rf_mark,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag
);
    logic [TAG_W-1:0] tags [ENTRIES];
    logic             own_fill;
    logic             page_differs;

    assign own_fill     = (rf_kind == 2'(KIND_ID));
    assign page_differs = (tags[rf_idx][VPN_W-1:0] != rf_vpn);
    assign rd_tag       = tags[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tags[i] <= '1;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) tags[i] <= '1;
        end else if (rf_en) begin
            if (own_fill)
                tags[rf_idx] <= {rf_mark, rf_vpn};
            else if (page_differs)
                tags[rf_idx] <= '1;
        end
    end

    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> tags[$past(rf_idx)] == '1); // R8
    AST_OWN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && !flush && own_fill) |=> tags[$past(rf_idx)] == {$past(rf_mark), $past(rf_vpn)}); // R5
    AST_FOREIGN_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && !flush && !own_fill && page_differs) |=> tags[$past(rf_idx)] == '1); // R6
endmodule

// File: rtl/tlb_offset_bank.sv
module tlb_offset_bank #(
    parameter int ENTRIES = 16,
    parameter int OFS_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [OFS_W-1:0] rd_ofs
);
    logic [OFS_W-1:0] words [ENTRIES];

    assign rd_ofs = words[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[wr_idx] <= wr_ofs;
        end
    end

    AST_WORD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> words[$past(wr_idx)] == $past(wr_ofs)); // R5
endmodule

// File: rtl/tlb_split_top.sv
module tlb_split_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int OFS_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [1:0]       lk_kind,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             rf_valid,
    input  logic [1:0]       rf_kind,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [OFS_W-1:0] rf_ofs,
    input  logic [2:0]       watch,
    output logic             out_valid,
    output logic             out_hit,
    output logic [OFS_W-1:0] out_ofs
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = VPN_W + 1;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] rf_idx;
    logic             rf_en;
    logic             data_wr;
    logic [TAG_W-1:0] rd_tag [NUM_KINDS];
    logic [TAG_W-1:0] sel_tag;
    logic [OFS_W-1:0] set_ofs;
    logic             hit_c;

    assign lk_idx  = lk_vpn[IDX_W-1:0];
    assign rf_idx  = rf_vpn[IDX_W-1:0];
    assign rf_en   = rf_valid && (rf_kind != KIND_NONE);
    assign data_wr = rf_en && !flush;

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_bank
        tlb_tag_bank #(
            .ENTRIES(ENTRIES),
            .VPN_W  (VPN_W),
            .KIND_ID(g)
        ) u_tags (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .rf_en  (rf_en),
            .rf_kind(rf_kind),
            .rf_idx (rf_idx),
            .rf_vpn (rf_vpn),
            .rf_mark(watch[g]),
            .rd_idx (lk_idx),
            .rd_tag (rd_tag[g])
        );
    end

    tlb_offset_bank #(
        .ENTRIES(ENTRIES),
        .OFS_W  (OFS_W)
    ) u_ofs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (data_wr),
        .wr_idx(rf_idx),
        .wr_ofs(rf_ofs),
        .rd_idx(lk_idx),
        .rd_ofs(set_ofs)
    );

    always_comb begin
        unique case (acc_kind_e'(lk_kind))
            KIND_FETCH: sel_tag = rd_tag[0];
            KIND_LOAD:  sel_tag = rd_tag[1];
            KIND_STORE: sel_tag = rd_tag[2];
            KIND_NONE:  sel_tag = '1;
        endcase
        hit_c = (sel_tag == {1'b0, lk_vpn});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_ofs   <= '0;
        end else begin
            out_valid <= lk_valid;
            out_hit   <= lk_valid && hit_c;
            out_ofs   <= (lk_valid && hit_c) ? set_ofs : '0;
        end
    end

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> out_valid); // R2
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !out_valid && !out_hit); // R2
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> out_ofs == '0); // R3
    AST_BAD_KIND_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == 2'd3) |=> !out_hit); // R10
endmodule

// File: tb/tlb_split_top_test.sv
`timescale 1ns/1ps
module tlb_split_top_test;
    localparam int E  = 4;
    localparam int VW = 4;
    localparam int OW = 8;
    localparam int NV = 1 << VW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          lk_valid = 1'b0;
    logic [1:0]    lk_kind = '0;
    logic [VW-1:0] lk_vpn = '0;
    logic          rf_valid = 1'b0;
    logic [1:0]    rf_kind = '0;
    logic [VW-1:0] rf_vpn = '0;
    logic [OW-1:0] rf_ofs = '0;
    logic [2:0]    watch = '0;
    logic          out_valid;
    logic          out_hit;
    logic [OW-1:0] out_ofs;

    int checks = 0;
    int errors = 0;

    logic [VW:0]   m_tag [3][E];
    logic [OW-1:0] m_ofs [E];

    always #2 clk = ~clk;

    tlb_split_top #(.ENTRIES(E), .VPN_W(VW), .OFS_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_vpn(lk_vpn),
        .rf_valid(rf_valid), .rf_kind(rf_kind), .rf_vpn(rf_vpn), .rf_ofs(rf_ofs),
        .watch(watch), .out_valid(out_valid), .out_hit(out_hit), .out_ofs(out_ofs)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < E; i++) m_tag[k][i] = '1;
    endtask

    task automatic model_fill(input int kd, input int v, input int o, input logic [2:0] w);
        int ix;
        if (kd == 3) return;
        ix = v % E;
        for (int k = 0; k < 3; k++)
            if (m_tag[k][ix][VW-1:0] != VW'(v)) m_tag[k][ix] = '1;
        m_tag[kd][ix] = {w[kd], VW'(v)};
        m_ofs[ix] = OW'(o);
    endtask

    function automatic int exp_hit(input int kd, input int v);
        if (kd == 3) return 0;
        return (m_tag[kd][v % E] == {1'b0, VW'(v)}) ? 1 : 0;
    endfunction

    task automatic refill(input int kd, input int v, input int o, input logic [2:0] w);
        @(negedge clk);
        rf_valid = 1'b1; rf_kind = 2'(kd); rf_vpn = VW'(v); rf_ofs = OW'(o); watch = w;
        @(negedge clk);
        rf_valid = 1'b0; watch = '0;
        model_fill(kd, v, o, w);
    endtask

    task automatic lookup(input string req, input int kd, input int v);
        int eh;
        eh = exp_hit(kd, v);
        @(negedge clk);
        lk_valid = 1'b1; lk_kind = 2'(kd); lk_vpn = VW'(v);
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, int'(out_valid), 1);
        check(req, int'(out_hit), eh);
        check(req, int'(out_ofs), eh ? int'(m_ofs[v % E]) : 0);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_flush();
        for (int i = 0; i < E; i++) m_ofs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs and cold misses
        check("R1", int'(out_valid), 0);
        for (int k = 0; k < 3; k++) lookup("R1", k, 5);

        // R2: no result without lookup
        @(negedge clk);
        check("R2", int'(out_valid), 0);

        // R3 basic hit
        refill(0, 3, 8'h5a, 3'b000);
        lookup("R3", 0, 3);
        check("R3", int'(out_ofs), 8'h5a);
        lookup("R3", 1, 3);

        // R5: load refill same page keeps fetch, shares new offset
        refill(1, 3, 8'h77, 3'b000);
        lookup("R5", 0, 3);
        check("R5", int'(out_ofs), 8'h77);
        lookup("R5", 1, 3);

        // R4: alias in same set misses
        lookup("R4", 0, 7);
        check("R4", int'(out_hit), 0);

        // R6: store refill on alias page evicts fetch and load
        refill(2, 7, 8'h21, 3'b000);
        lookup("R6", 0, 3);
        check("R6", int'(out_hit), 0);
        lookup("R6", 1, 3);
        lookup("R6", 2, 7);

        // R7: watch marks the tag
        refill(1, 9, 8'h44, 3'b010);
        lookup("R7", 1, 9);
        check("R7", int'(out_hit), 0);
        refill(1, 9, 8'h45, 3'b100);
        lookup("R7", 1, 9);
        check("R7", int'(out_hit), 1);

        // R10: kind 3 misses and its refill changes nothing
        lookup("R10", 3, 9);
        refill(3, 9, 8'hee, 3'b000);
        lookup("R10", 1, 9);
        check("R10", int'(out_ofs), 8'h45);

        // R9: same-cycle refill and lookup sees old contents
        @(negedge clk);
        rf_valid = 1'b1; rf_kind = 2'd2; rf_vpn = 4'd12; rf_ofs = 8'h31;
        lk_valid = 1'b1; lk_kind = 2'd2; lk_vpn = 4'd12;
        @(negedge clk);
        rf_valid = 1'b0; lk_valid = 1'b0;
        check("R9", int'(out_hit), 0);
        model_fill(2, 12, 8'h31, 3'b000);
        lookup("R9", 2, 12);
        check("R9", int'(out_hit), 1);

        // R8: flush with refill in same cycle leaves nothing
        @(negedge clk);
        flush = 1'b1; rf_valid = 1'b1; rf_kind = 2'd0; rf_vpn = 4'd1; rf_ofs = 8'h10;
        lk_valid = 1'b1; lk_kind = 2'd2; lk_vpn = 4'd12;
        @(negedge clk);
        flush = 1'b0; rf_valid = 1'b0; lk_valid = 1'b0;
        check("R9", int'(out_hit), 1);
        model_flush();
        lookup("R8", 0, 1);
        check("R8", int'(out_hit), 0);
        for (int v = 0; v < NV; v++) lookup("R8", 2, v);

        // Sweep: every page and kind refilled, every page and kind looked up
        for (int s = 0; s < 3 * NV; s++) begin
            int kd = s % 3;
            int v  = (s * 7) % NV;
            refill(kd, v, (s * 37 + 11) % 256, 3'((s * 5) % 8 == 1 ? 3'b111 : 3'((s / 3) % 2 == 1 ? 3'b001 << kd : 0)));
            for (int k = 0; k < 3; k++)
                for (int u = 0; u < NV; u++)
                    lookup(exp_hit(k, u) ? "R3" : "R6", k, u);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule